// File: doc/BRIEF.md
# LIN Frame and Response Start Control

This block is the start-control register of a LIN/UART controller. It holds two single-bit start flags that only software can set and only hardware can clear. The frame start flag launches a header or wake-up transfer, and while it is set it also enables counting of the low width of the incoming line for wake-up detection. The response start flag releases one response data group at a time when the controller runs with header and response handled separately.

Software writes an 8-bit value. A 1 in a start position sets that flag, and a 0 leaves it as it is. The write is gated by the operating mode. The response flag additionally needs the frame flag to be set already and frame separate mode to be selected. The controller clears the flags through done pulses, and entering reset mode clears both. A one-cycle go pulse marks each new response arm. Long responses are sent as successive groups of up to 8 bytes, so software re-arms the response flag once per group.

Top module: `lin_start_ctrl`

## Requirements
- R1: After reset, both start flags are 0, the read port returns 0x00, and `resp_go_o` is 0.
- R2: The read port returns the frame flag in bit 0 and the response flag in bit 1. Bits 7 to 2 always read 0, and writing 1 to them changes nothing that can be read.
- R3: Writing a 1 to a start bit position sets that flag on the next clock edge. Writing a 0 never clears a flag that is set.
- R4: While `lin_rst_mode_i` is 1, writes do not set either flag. At every clock edge where `lin_rst_mode_i` is 1, both flags become 0, and this holds even when a write that sets them arrives in the same cycle.
- R5: `frame_done_i` or `wake_done_i` clears the frame flag at the next edge. If a software set arrives in the same cycle, the clear takes priority.
- R6: `wake_cnt_en_o` is 1 exactly while the frame flag is 1.
- R7: A write of 1 to bit 1 sets the response flag only if the frame flag is already 1 and `frame_sep_i` is 1. Otherwise it is ignored.
- R8: `group_done_i` or `frame_done_i` clears the response flag at the next edge. If a software set arrives in the same cycle, the clear takes priority.
- R9: `resp_go_o` is high for exactly one cycle, namely the first cycle in which the response flag reads 1 after being 0. Re-arming after each group completion produces one pulse per group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register read value |
| lin_rst_mode_i | input | 1 | Controller is in LIN reset mode |
| frame_sep_i | input | 1 | Frame separate mode selected |
| frame_done_i | input | 1 | Frame communication complete pulse |
| wake_done_i | input | 1 | Wake-up communication complete pulse |
| group_done_i | input | 1 | Response data group complete pulse |
| frame_start_o | output | 1 | Frame / wake-up start flag |
| resp_start_o | output | 1 | Response start flag |
| wake_cnt_en_o | output | 1 | Enable for wake-up low-width counting |
| resp_go_o | output | 1 | One-cycle pulse when the response flag is armed |

## Verification
The hardest situation to reach is a hardware clear and a software set of the same flag meeting in one cycle. The bench drives the write strobe and the done pulse, or the rise of the reset-mode flag, on the same falling edge, so that both are sampled by the same rising edge. The multi-group response case is reached as follows: the bench holds the frame flag set, then repeats a cycle of arm, go pulse and group done three times. It checks that every re-arm yields exactly one go pulse and that no pulse appears while the flag is unarmed.

// File: rtl/lin_start_pkg.sv
package lin_start_pkg;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned FRM_POS = 0;
  localparam int unsigned RSP_POS = 1;

  typedef struct packed {
    logic rsp;
    logic frm;
  } start_req_t;
endpackage

// File: rtl/lin_start_wr_dec.sv
module lin_start_wr_dec
  import lin_start_pkg::*;
#(
  parameter int unsigned DATA_W = CTRL_W
) (
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lin_rst_mode_i,
  input  logic              frame_sep_i,
  input  logic              frm_q_i,
  output start_req_t        set_o
);
  logic wr_ok;

  assign wr_ok      = wr_en_i & ~lin_rst_mode_i;
  assign set_o.frm  = wr_ok & wr_data_i[FRM_POS];
  // response arm needs a running frame in separate mode
  assign set_o.rsp  = wr_ok & wr_data_i[RSP_POS] & frm_q_i & frame_sep_i;
endmodule

// File: rtl/lin_start_bit.sv
module lin_start_bit #(
  parameter bit EDGE_PULSE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic rise_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (clr_i)  q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
  end

  assign q_o = q_q;

  generate
    if (EDGE_PULSE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= q_q;
      end
      assign rise_o = q_q & ~prev_q;
    end else begin : g_no_edge
      assign rise_o = 1'b0;
    end
  endgenerate

  // R5 R8
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);

  // R3
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o);

  // R3
  no_sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/lin_start_ctrl.sv
module lin_start_ctrl
  import lin_start_pkg::*;
#(
  parameter int unsigned DATA_W = CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              lin_rst_mode_i,
  input  logic              frame_sep_i,
  input  logic              frame_done_i,
  input  logic              wake_done_i,
  input  logic              group_done_i,
  output logic              frame_start_o,
  output logic              resp_start_o,
  output logic              wake_cnt_en_o,
  output logic              resp_go_o
);
  start_req_t set_req;
  logic       frm_q, rsp_q;
  logic       frm_clr, rsp_clr;
  logic       frm_rise_unused;

  lin_start_wr_dec #(.DATA_W(DATA_W)) u_dec (
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .lin_rst_mode_i (lin_rst_mode_i),
    .frame_sep_i    (frame_sep_i),
    .frm_q_i        (frm_q),
    .set_o          (set_req)
  );

  assign frm_clr = lin_rst_mode_i | frame_done_i | wake_done_i;
  assign rsp_clr = lin_rst_mode_i | frame_done_i | group_done_i;

  lin_start_bit #(.EDGE_PULSE(1'b0)) u_frm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_req.frm),
    .clr_i  (frm_clr),
    .q_o    (frm_q),
    .rise_o (frm_rise_unused)
  );

  lin_start_bit #(.EDGE_PULSE(1'b1)) u_rsp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_req.rsp),
    .clr_i  (rsp_clr),
    .q_o    (rsp_q),
    .rise_o (resp_go_o)
  );

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[FRM_POS] = frm_q;
    rd_data_o[RSP_POS] = rsp_q;
  end

  assign frame_start_o = frm_q;
  assign resp_start_o  = rsp_q;
  assign wake_cnt_en_o = frm_q;

  // R4
  rst_mode_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_rst_mode_i |=> (!frame_start_o && !resp_start_o));

  // R7
  rsp_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resp_start_o) |-> ($past(frame_start_o) && $past(frame_sep_i) && $past(wr_en_i)));

  // R9
  go_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_go_o |=> !resp_go_o);

  // R9
  go_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_go_o |-> (resp_start_o && !$past(resp_start_o)));

  // R5
  frm_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i || wake_done_i) |=> !frame_start_o);
endmodule

// File: tb/sim_lin_start_ctrl.sv
`timescale 1ns/1ps
module sim_lin_start_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rst_mode = 1'b0, fsep = 1'b0;
  logic       f_done = 1'b0, w_done = 1'b0, g_done = 1'b0;
  logic       frm, rsp, wcnt, go;
  int         n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  lin_start_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .lin_rst_mode_i(rst_mode), .frame_sep_i(fsep),
    .frame_done_i(f_done), .wake_done_i(w_done), .group_done_i(g_done),
    .frame_start_o(frm), .resp_start_o(rsp), .wake_cnt_en_o(wcnt), .resp_go_o(go)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, sample after the capturing edge
  task automatic step(input logic we, input logic [7:0] d, input logic fd, input logic wd, input logic gd);
    @(negedge clk);
    wr_en = we; wr_data = d; f_done = fd; w_done = wd; g_done = gd;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; f_done = 1'b0; w_done = 1'b0; g_done = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic clean();
    @(negedge clk); rst_mode = 1'b1;
    @(negedge clk); rst_mode = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 read", rd_data, 8'h00);
    chk("R1 go", {7'd0, go}, 8'h00);
  endtask

  task automatic t_set_and_map();
    clean(); fsep = 1'b0;
    wr(8'hFC);
    chk("R2 reserved bits", rd_data, 8'h00);
    wr(8'h01);
    chk("R3 frame set", rd_data, 8'h01);
    chk("R6 wake count", {7'd0, wcnt}, 8'h01);
    wr(8'h00);
    chk("R3 zero write keeps", rd_data, 8'h01);
    wr(8'h02);
    chk("R7 no sep mode", rd_data, 8'h01);
  endtask

  task automatic t_resp_gate();
    clean(); fsep = 1'b1;
    wr(8'h02);
    chk("R7 frame not set", rd_data, 8'h00);
    wr(8'h01);
    wr(8'h02);
    chk("R7 accepted", rd_data, 8'h03);
    chk("R9 go high", {7'd0, go}, 8'h01);
    @(negedge clk);
    chk("R9 go one cycle", {7'd0, go}, 8'h00);
    wr(8'hFC);
    chk("R2 reserved write", rd_data, 8'h03);
  endtask

  task automatic t_reset_mode();
    clean(); fsep = 1'b1;
    wr(8'h01); wr(8'h02);
    @(negedge clk); rst_mode = 1'b1; wr_en = 1'b1; wr_data = 8'h03;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R4 clear on entry", rd_data, 8'h00);
    wr(8'h01);
    chk("R4 write ignored", rd_data, 8'h00);
    @(negedge clk); rst_mode = 1'b0;
  endtask

  task automatic t_frame_clear();
    clean(); fsep = 1'b1;
    wr(8'h01); wr(8'h02);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R5 R8 frame done", rd_data, 8'h00);
    wr(8'h01);
    step(1'b1, 8'h01, 1'b0, 1'b1, 1'b0);
    chk("R5 wake done beats set", rd_data, 8'h00);
    chk("R6 count off", {7'd0, wcnt}, 8'h00);
  endtask

  task automatic t_groups();
    int pulses = 0;
    clean(); fsep = 1'b1;
    wr(8'h01);
    for (int g = 0; g < 3; g++) begin
      wr(8'h02);
      if (go) pulses++;
      chk("R9 armed", rd_data, 8'h03);
      @(negedge clk);
      if (go) pulses++;
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      chk("R8 group done", rd_data, 8'h01);
      chk("R9 no go idle", {7'd0, go}, 8'h00);
    end
    chk("R9 pulse count", pulses[7:0], 8'd3);
    wr(8'h02);
    step(1'b1, 8'h02, 1'b0, 1'b0, 1'b1);
    chk("R8 clear beats set", rd_data, 8'h01);
  endtask

  initial begin : watchdog
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_and_map();
    t_resp_gate();
    t_reset_mode();
    t_frame_clear();
    t_groups();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule